// File: doc/BRIEF.md
# Thermal Mailbox Command Dispatcher

This block serves a host-side mailbox used for thermal management. Each request carries an 8-bit request type and a 32-bit send word, and is marked by a one-cycle `req_valid` pulse. The block decodes the type and acts on it. It then answers one cycle later with a one-cycle response strobe, a completion code and a 32-bit get word.

Six request types are recognised:

- A ping that always passes.
- A write of the throttling control word.
- Reads of the average-core and uncore temperatures, which are supplied on input ports.
- A write of an upper P-state ratio limit.
- A read-back of that limit.

The throttling word and the P-state limit are held in internal registers and driven out continuously. Every other request type is refused with a failure code and has no side effect. The serial transport that delivers requests and the sensors that produce the temperatures sit outside this block.

Top module: `tmbx_dispatch`

## Requirements
- R1: After reset, `throttle_word` and `pstate_limit` are zero and `rsp_valid` is low.
- R2: Type 0x00 (ping) answers with code 0x40 and a get word of zero.
- R3: Type 0x0C loads all 32 bits of `req_data` into `throttle_word`, visible after the request's clock edge. It answers 0x40 with a get word of zero.
- R4: Type 0x21 answers 0x40 with `avg_temp`, as sampled in the request cycle and zero-extended, as the get word.
- R5: Type 0x22 answers 0x40 with `uncore_temp`, as sampled in the request cycle and zero-extended, as the get word.
- R6: Type 0x23 loads `req_data[PLIM_W-1:0]` into `pstate_limit`, visible after the request's clock edge. It answers 0x40 with a get word of zero.
- R7: Type 0x24 answers 0x40 with the stored limit, zero-extended. Before any 0x23 has been accepted, that value is zero.
- R8: Any other type answers with code 0x90 and a get word of zero. Neither `throttle_word` nor `pstate_limit` changes.
- R9: `rsp_valid` is high in exactly the cycle after each cycle with `req_valid` high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_type | input | 8 | Request type code |
| req_data | input | DW | Send word |
| avg_temp | input | TEMP_W | Average core temperature |
| uncore_temp | input | TEMP_W | Uncore temperature |
| rsp_valid | output | 1 | Response strobe |
| rsp_code | output | 8 | Completion code (0x40 pass, 0x90 fail) |
| rsp_data | output | DW | Get word |
| throttle_word | output | DW | Stored throttling control word |
| pstate_limit | output | PLIM_W | Stored P-state ratio limit |

## Verification
The response code and get word are due one clock edge after the request. The stored registers change on that same edge. The bench drives each request on a falling edge and samples response, code, data and both register outputs on the next falling edge, just after that single rising edge. It then inserts an idle cycle and checks on the following falling edge that the strobe has dropped. Temperature inputs are held across the request edge so that the value the bench expects is the one the block captured.

// File: rtl/tmbx_pkg.sv
package tmbx_pkg;
  localparam int TYPE_W = 8;
  localparam logic [7:0] CC_PASS = 8'h40;
  localparam logic [7:0] CC_FAIL = 8'h90;

  localparam logic [TYPE_W-1:0] T_PING   = 8'h00;
  localparam logic [TYPE_W-1:0] T_THR_WR = 8'h0C;
  localparam logic [TYPE_W-1:0] T_AVG_RD = 8'h21;
  localparam logic [TYPE_W-1:0] T_UNC_RD = 8'h22;
  localparam logic [TYPE_W-1:0] T_LIM_WR = 8'h23;
  localparam logic [TYPE_W-1:0] T_LIM_RD = 8'h24;

  typedef enum logic [2:0] {
    CMD_PING, CMD_THR_WR, CMD_AVG_RD, CMD_UNC_RD, CMD_LIM_WR, CMD_LIM_RD, CMD_BAD
  } cmd_e;

  function automatic cmd_e decode_type(input logic [TYPE_W-1:0] t);
    case (t)
      T_PING:   return CMD_PING;
      T_THR_WR: return CMD_THR_WR;
      T_AVG_RD: return CMD_AVG_RD;
      T_UNC_RD: return CMD_UNC_RD;
      T_LIM_WR: return CMD_LIM_WR;
      T_LIM_RD: return CMD_LIM_RD;
      default:  return CMD_BAD;
    endcase
  endfunction
endpackage

// File: rtl/tmbx_decoder.sv
module tmbx_decoder
  import tmbx_pkg::*;
(
  input  logic              req_valid,
  input  logic [TYPE_W-1:0] req_type,
  output cmd_e              cmd,
  output logic              cmd_legal,
  output logic              wr_thr_en,
  output logic              wr_lim_en
);
  always_comb begin
    cmd       = decode_type(req_type);
    cmd_legal = (cmd != CMD_BAD);
    wr_thr_en = req_valid && (cmd == CMD_THR_WR);
    wr_lim_en = req_valid && (cmd == CMD_LIM_WR);
  end
endmodule

// File: rtl/tmbx_regs.sv
module tmbx_regs #(
  parameter int DW     = 32,
  parameter int PLIM_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_thr_en,
  input  logic              wr_lim_en,
  input  logic [DW-1:0]     wr_data,
  output logic [DW-1:0]     thr_q,
  output logic [PLIM_W-1:0] lim_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q <= '0;
      lim_q <= '0;
    end else begin
      if (wr_thr_en) thr_q <= wr_data;
      if (wr_lim_en) lim_q <= wr_data[PLIM_W-1:0];
    end
  end

  p_thr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_thr_en |=> $stable(thr_q));
  p_lim_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_lim_en |=> $stable(lim_q));
  p_thr_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_thr_en |=> thr_q == $past(wr_data));
  p_lim_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lim_en |=> lim_q == $past(wr_data[PLIM_W-1:0]));
endmodule

// File: rtl/tmbx_resp.sv
module tmbx_resp
  import tmbx_pkg::*;
#(
  parameter int DW     = 32,
  parameter int TEMP_W = 16,
  parameter int PLIM_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  cmd_e              cmd,
  input  logic [TEMP_W-1:0] avg_temp,
  input  logic [TEMP_W-1:0] uncore_temp,
  input  logic [PLIM_W-1:0] lim_q,
  output logic              rsp_valid,
  output logic [7:0]        rsp_code,
  output logic [DW-1:0]     rsp_data
);
  localparam int TPAD = DW - TEMP_W;
  localparam int LPAD = DW - PLIM_W;

  function automatic logic [DW-1:0] widen_temp(input logic [TEMP_W-1:0] v);
    return {{TPAD{1'b0}}, v};
  endfunction

  function automatic logic [DW-1:0] widen_lim(input logic [PLIM_W-1:0] v);
    return {{LPAD{1'b0}}, v};
  endfunction

  logic [DW-1:0] get_d;
  logic [7:0]    code_d;

  always_comb begin
    code_d = CC_PASS;
    get_d  = '0;
    case (cmd)
      CMD_AVG_RD: get_d = widen_temp(avg_temp);
      CMD_UNC_RD: get_d = widen_temp(uncore_temp);
      CMD_LIM_RD: get_d = widen_lim(lim_q);
      CMD_BAD:    code_d = CC_FAIL;
      default:    get_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_code  <= 8'h00;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_code <= code_d;
        rsp_data <= get_d;
      end
    end
  end

  p_rsp_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_rsp_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  p_bad_fails_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && cmd == CMD_BAD) |=> (rsp_code == CC_FAIL && rsp_data == '0));
  p_code_known_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_code == CC_PASS || rsp_code == CC_FAIL));
endmodule

// File: rtl/tmbx_dispatch.sv
module tmbx_dispatch
  import tmbx_pkg::*;
#(
  parameter int DW     = 32,
  parameter int TEMP_W = 16,
  parameter int PLIM_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [7:0]        req_type,
  input  logic [DW-1:0]     req_data,
  input  logic [TEMP_W-1:0] avg_temp,
  input  logic [TEMP_W-1:0] uncore_temp,
  output logic              rsp_valid,
  output logic [7:0]        rsp_code,
  output logic [DW-1:0]     rsp_data,
  output logic [DW-1:0]     throttle_word,
  output logic [PLIM_W-1:0] pstate_limit
);
  cmd_e cmd;
  logic cmd_legal;
  logic wr_thr_en;
  logic wr_lim_en;

  tmbx_decoder u_dec (
    .req_valid (req_valid),
    .req_type  (req_type),
    .cmd       (cmd),
    .cmd_legal (cmd_legal),
    .wr_thr_en (wr_thr_en),
    .wr_lim_en (wr_lim_en)
  );

  tmbx_regs #(.DW(DW), .PLIM_W(PLIM_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_thr_en (wr_thr_en),
    .wr_lim_en (wr_lim_en),
    .wr_data   (req_data),
    .thr_q     (throttle_word),
    .lim_q     (pstate_limit)
  );

  tmbx_resp #(.DW(DW), .TEMP_W(TEMP_W), .PLIM_W(PLIM_W)) u_resp (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .cmd         (cmd),
    .avg_temp    (avg_temp),
    .uncore_temp (uncore_temp),
    .lim_q       (pstate_limit),
    .rsp_valid   (rsp_valid),
    .rsp_code    (rsp_code),
    .rsp_data    (rsp_data)
  );

  p_ping_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_type == 8'h00) |=> (rsp_code == CC_PASS && rsp_data == '0));
  p_illegal_nowrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !cmd_legal) |=> ($stable(throttle_word) && $stable(pstate_limit)));
  p_limrd_echo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_type == 8'h24) |=> rsp_data == DW'($past(pstate_limit)));
endmodule

// File: tb/tmbx_dispatch_tb_top.sv
module tmbx_dispatch_tb_top;
  localparam int DW = 32;
  localparam int TEMP_W = 16;
  localparam int PLIM_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic [7:0]        req_type = 8'h00;
  logic [DW-1:0]     req_data = '0;
  logic [TEMP_W-1:0] avg_temp = '0;
  logic [TEMP_W-1:0] uncore_temp = '0;
  logic              rsp_valid;
  logic [7:0]        rsp_code;
  logic [DW-1:0]     rsp_data;
  logic [DW-1:0]     throttle_word;
  logic [PLIM_W-1:0] pstate_limit;

  int n_cmp = 0;
  int n_bad = 0;
  logic [DW-1:0]     m_thr = '0;
  logic [PLIM_W-1:0] m_lim = '0;

  always #5 clk = ~clk;

  tmbx_dispatch #(.DW(DW), .TEMP_W(TEMP_W), .PLIM_W(PLIM_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_type(req_type),
    .req_data(req_data), .avg_temp(avg_temp), .uncore_temp(uncore_temp),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_data(rsp_data),
    .throttle_word(throttle_word), .pstate_limit(pstate_limit)
  );

  function automatic bit known_type(input logic [7:0] t);
    return t == 8'h00 || t == 8'h0C || t == 8'h21 || t == 8'h22 ||
           t == 8'h23 || t == 8'h24;
  endfunction

  function automatic logic [DW-1:0] want_data(input logic [7:0] t,
      input logic [TEMP_W-1:0] a, input logic [TEMP_W-1:0] u,
      input logic [PLIM_W-1:0] l);
    logic [DW-1:0] r;
    r = '0;
    if (t == 8'h21) r[TEMP_W-1:0] = a;
    else if (t == 8'h22) r[TEMP_W-1:0] = u;
    else if (t == 8'h24) r[PLIM_W-1:0] = l;
    return r;
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [7:0] t);
    case (t)
      8'h00: return "R2";
      8'h0C: return "R3";
      8'h21: return "R4";
      8'h22: return "R5";
      8'h23: return "R6";
      8'h24: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic send(input logic [7:0] t, input logic [DW-1:0] d);
    logic [DW-1:0] e_data;
    logic [7:0]    e_code;
    string         tg;
    tg = tag_of(t);
    @(negedge clk);
    req_valid   = 1'b1;
    req_type    = t;
    req_data    = d;
    avg_temp    = TEMP_W'($urandom);
    uncore_temp = TEMP_W'($urandom);
    e_data = want_data(t, avg_temp, uncore_temp, m_lim);
    e_code = known_type(t) ? 8'h40 : 8'h90;
    if (t == 8'h0C) m_thr = d;
    if (t == 8'h23) m_lim = d[PLIM_W-1:0];
    @(negedge clk);
    req_valid = 1'b0;
    check({tg, " R9 valid"}, DW'(rsp_valid), DW'(1'b1));
    check({tg, " code"}, DW'(rsp_code), DW'(e_code));
    check({tg, " data"}, rsp_data, e_data);
    check({tg, " thr"}, throttle_word, m_thr);
    check({tg, " lim"}, DW'(pstate_limit), DW'(m_lim));
    @(negedge clk);
    check("R9 idle", DW'(rsp_valid), DW'(1'b0));
  endtask

  initial begin
    #2_000_000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] pool [6];
    pool[0] = 8'h00; pool[1] = 8'h0C; pool[2] = 8'h21;
    pool[3] = 8'h22; pool[4] = 8'h23; pool[5] = 8'h24;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 thr", throttle_word, '0);
    check("R1 lim", DW'(pstate_limit), '0);
    check("R1 valid", DW'(rsp_valid), '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 no req", DW'(rsp_valid), '0);
    // directed corner cases
    send(8'h24, 32'hFFFF_FFFF);   // R7 before any write: zero
    send(8'h00, 32'h1234_5678);   // R2 ping
    send(8'h0C, 32'hDEAD_BEEF);   // R3
    send(8'h23, 32'hABCD_EF5A);   // R6 low bits only
    send(8'h24, 32'h0);           // R7 readback
    send(8'h25, 32'h1111_1111);   // R8 unknown
    send(8'h0D, 32'h2222_2222);   // R8 neighbour of write type
    send(8'hFF, 32'h3333_3333);   // R8
    send(8'h21, 32'h0);           // R4
    send(8'h22, 32'h0);           // R5
    // constrained random
    for (int i = 0; i < 300; i++) begin
      logic [7:0] t;
      if ($urandom_range(0, 3) == 0) t = 8'($urandom);
      else t = pool[$urandom_range(0, 5)];
      send(t, $urandom);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule